// File: doc/BRIEF.md
# Packet-Atomic Round-Robin Stream Merger

This block joins several independent packet streams onto a single downstream streaming port. Every input carries valid, ready, start-of-packet, end-of-packet and a wide data word. Only one input is served at a time, and an input keeps the port from the beat it starts on until its end-of-packet beat has been taken. When that packet is finished, the next input to be served is the nearest one that is requesting, counting forward in cyclic order from the input served last.

All outputs come straight from registers. The ready returned to each source is also a register, so no combinational path runs from the downstream ready back to the sources. A downstream stall can therefore catch one beat that a source has already handed over. A one-entry holding register keeps that beat and sends it out before any newer beat once the downstream side accepts again. Start-of-packet, end-of-packet and data pass through unchanged.

Top module: `pkt_rr_mux`

## Requirements
- R1: During and directly after reset, out_valid and every src_ready are low. The last-served pointer resets to the highest-numbered input, so input 0 has first priority.
- R2: At most one src_ready bit is high in any cycle. An input that is not selected always sees ready low.
- R3: After a beat from an input is accepted and that beat is not end-of-packet, no other input has ready high in the next cycle. On the output, every beat from a start-of-packet beat to its end-of-packet beat comes from one input.
- R4: Between packets, the next input served is the first requesting input after the last-served one in the cyclic order 0, 1, 2, 3, 0. If no other input is requesting, the same input may be served again.
- R5: In a cycle where out_valid is high and out_ready is low, out_valid, out_sop, out_eop and out_data all keep their values into the next cycle.
- R6: During one continuous downstream stall, at most one beat is accepted from the sources. While that beat is held, every src_ready is low.
- R7: For each input, the output carries its beats in order, with no loss, duplicates or changes to data, start-of-packet or end-of-packet. A beat accepted while nothing is held and the output can move is on the output in the next cycle.
- R8: If the output beat is taken, nothing is held and nothing is accepted, out_valid is low in the next cycle. After the last packet drains, the block rests with out_valid and all src_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | NUM_SRC | Per-input beat valid |
| src_ready | output | NUM_SRC | Per-input beat accept; registered |
| src_sop | input | NUM_SRC | Per-input start-of-packet flag |
| src_eop | input | NUM_SRC | Per-input end-of-packet flag |
| src_data | input | NUM_SRC*DATA_W | Input data words; input i occupies bits [i*DATA_W +: DATA_W] |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accept |
| out_sop | output | 1 | Output start-of-packet flag |
| out_eop | output | 1 | Output end-of-packet flag |
| out_data | output | DATA_W | Output data word |

## Verification
The hardest case to reach is a downstream stall that starts in the same cycle a source beat is accepted. That beat has to land in the holding register, source ready has to drop, and the held beat has to come out first when the stall clears. The case is harder still when it falls on an end-of-packet beat just before the arbiter moves to another input. The stimulus reaches it with two kinds of downstream ready: a pseudo-random pattern and a long periodic stall. Both run against multi-beat packets of mixed lengths on all inputs, and in one run the sources also drop valid at random. Each beat is tagged with its input, packet and beat number, so any loss, duplicate, reorder or interleave shows up in the captured output stream.

// File: rtl/pkt_mux_pkg.sv
package pkt_mux_pkg;

   typedef enum logic {
      LOCK_IDLE = 1'b0,
      LOCK_BUSY = 1'b1
   } lock_st_e;

   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pkt_mux_rr_arb.sv
module pkt_mux_rr_arb #(
   parameter int N     = 4,
   parameter int SEL_W = 2
) (
   input  logic [N-1:0]     req,
   input  logic [SEL_W-1:0] prev_sel,
   output logic             found,
   output logic [SEL_W-1:0] win
);

   // scan from the farthest offset to the nearest so the nearest requester wins
   always_comb begin
      found = 1'b0;
      win   = prev_sel;
      for (int k = N; k >= 1; k--) begin
         if (req[(int'(prev_sel) + k) % N]) begin
            found = 1'b1;
            win   = SEL_W'((int'(prev_sel) + k) % N);
         end
      end
   end

endmodule

// File: rtl/pkt_mux_grant.sv
module pkt_mux_grant
   import pkt_mux_pkg::*;
#(
   parameter int N     = 4,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     src_valid,
   input  logic [N-1:0]     src_eop,
   input  logic             hold_next,
   output logic [SEL_W-1:0] sel,
   output logic [N-1:0]     src_ready,
   output logic             acc,
   output logic             acc_eop
);

   lock_st_e         st_q, st_n;
   logic [SEL_W-1:0] sel_n;
   logic             rdy_q, rdy_n;
   logic             arb_found;
   logic [SEL_W-1:0] arb_win;

   pkt_mux_rr_arb #(.N(N), .SEL_W(SEL_W)) i_arb (
      .req      (src_valid),
      .prev_sel (sel),
      .found    (arb_found),
      .win      (arb_win)
   );

   assign acc     = rdy_q & src_valid[sel];
   assign acc_eop = acc & src_eop[sel];

   always_comb begin
      st_n  = st_q;
      sel_n = sel;
      if (st_q == LOCK_IDLE) begin
         if (arb_found) begin
            st_n  = LOCK_BUSY;
            sel_n = arb_win;
         end
      end else if (acc_eop) begin
         st_n = LOCK_IDLE;
      end
      rdy_n = (st_n == LOCK_BUSY) && !hold_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= LOCK_IDLE;
         sel   <= SEL_W'(N - 1);
         rdy_q <= 1'b0;
      end else begin
         st_q  <= st_n;
         sel   <= sel_n;
         rdy_q <= rdy_n;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_rdy
      assign src_ready[i] = rdy_q && (sel == SEL_W'(i));
   end

endmodule

// File: rtl/pkt_mux_beat_path.sv
module pkt_mux_beat_path #(
   parameter int N          = 4,
   parameter int DW         = 512,
   parameter int SEL_W      = 2,
   parameter bit CLEAR_DATA = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic            acc,
   input  logic [N-1:0]    src_sop,
   input  logic [N-1:0]    src_eop,
   input  logic [N*DW-1:0] src_data,
   input  logic            out_ready,
   output logic            out_valid,
   output logic            out_sop,
   output logic            out_eop,
   output logic [DW-1:0]   out_data,
   output logic            hold_full,
   output logic            hold_next
);

   logic [DW-1:0] lane [N];
   logic          can_load;
   logic          hold_sop, hold_eop;
   logic [DW-1:0] hold_data;
   logic          load_out;
   logic          nxt_sop, nxt_eop;
   logic [DW-1:0] nxt_data;

   for (genvar i = 0; i < N; i++) begin : g_lane
      assign lane[i] = src_data[i*DW +: DW];
   end

   assign can_load  = !out_valid || out_ready;
   assign hold_next = can_load ? 1'b0 : (hold_full || acc);
   assign load_out  = can_load && (hold_full || acc);
   assign nxt_sop   = hold_full ? hold_sop  : src_sop[sel];
   assign nxt_eop   = hold_full ? hold_eop  : src_eop[sel];
   assign nxt_data  = hold_full ? hold_data : lane[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         out_valid <= 1'b0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
         hold_sop  <= 1'b0;
         hold_eop  <= 1'b0;
      end else begin
         hold_full <= hold_next;
         if (can_load) begin
            out_valid <= hold_full || acc;
         end
         if (load_out) begin
            out_sop <= nxt_sop;
            out_eop <= nxt_eop;
         end
         if (acc) begin
            hold_sop <= src_sop[sel];
            hold_eop <= src_eop[sel];
         end
      end
   end

   if (CLEAR_DATA) begin : g_data_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_data  <= '0;
            hold_data <= '0;
         end else begin
            if (load_out) out_data  <= nxt_data;
            if (acc)      hold_data <= lane[sel];
         end
      end
   end else begin : g_data_norst
      always_ff @(posedge clk) begin
         if (load_out) out_data  <= nxt_data;
         if (acc)      hold_data <= lane[sel];
      end
   end

endmodule

// File: rtl/pkt_rr_mux.sv
module pkt_rr_mux
   import pkt_mux_pkg::*;
#(
   parameter int NUM_SRC    = 4,
   parameter int DATA_W     = 512,
   parameter bit CLEAR_DATA = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        src_valid,
   output logic [NUM_SRC-1:0]        src_ready,
   input  logic [NUM_SRC-1:0]        src_sop,
   input  logic [NUM_SRC-1:0]        src_eop,
   input  logic [NUM_SRC*DATA_W-1:0] src_data,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic                      out_sop,
   output logic                      out_eop,
   output logic [DATA_W-1:0]         out_data
);

   localparam int SEL_W = sel_width(NUM_SRC);

   if (NUM_SRC < 2) begin : g_bad_src
      $error("pkt_rr_mux: NUM_SRC must be at least 2");
   end
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("pkt_rr_mux: DATA_W must be a whole number of bytes");
   end

   logic [SEL_W-1:0] sel;
   logic             acc;
   logic             acc_eop;
   logic             hold_full;
   logic             hold_next;

   pkt_mux_grant #(.N(NUM_SRC), .SEL_W(SEL_W)) i_grant (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_valid (src_valid),
      .src_eop   (src_eop),
      .hold_next (hold_next),
      .sel       (sel),
      .src_ready (src_ready),
      .acc       (acc),
      .acc_eop   (acc_eop)
   );

   pkt_mux_beat_path #(
      .N(NUM_SRC), .DW(DATA_W), .SEL_W(SEL_W), .CLEAR_DATA(CLEAR_DATA)
   ) i_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .acc       (acc),
      .src_sop   (src_sop),
      .src_eop   (src_eop),
      .src_data  (src_data),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_sop   (out_sop),
      .out_eop   (out_eop),
      .out_data  (out_data),
      .hold_full (hold_full),
      .hold_next (hold_next)
   );

   logic unused_eop;
   assign unused_eop = acc_eop;

endmodule

// File: rtl/pkt_rr_mux_chk.sv
module pkt_rr_mux_chk #(
   parameter int N  = 4,
   parameter int DW = 512
) (
   input logic          clk,
   input logic          rst_n,
   input logic [N-1:0]  src_valid,
   input logic [N-1:0]  src_ready,
   input logic [N-1:0]  src_eop,
   input logic          out_valid,
   input logic          out_ready,
   input logic          out_sop,
   input logic          out_eop,
   input logic [DW-1:0] out_data,
   input logic          hold_full
);

   logic [N-1:0] take;
   logic         any_take;
   logic         take_eop;

   assign take     = src_valid & src_ready;
   assign any_take = |take;
   assign take_eop = |(take & src_eop);

   assert_ready_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_ready));

   assert_packet_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (any_take && !take_eop) |=> ((src_ready & ~$past(take)) == '0));

   assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_sop) && $stable(out_eop) && $stable(out_data)));

   assert_held_blocks_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hold_full |-> (src_ready == '0));

   assert_accept_forwarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (any_take && !hold_full && (!out_valid || out_ready)) |=> out_valid);

   assert_idle_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !hold_full && !any_take) |=> !out_valid);

endmodule

bind pkt_rr_mux pkt_rr_mux_chk #(.N(NUM_SRC), .DW(DATA_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_valid (src_valid),
   .src_ready (src_ready),
   .src_eop   (src_eop),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_sop   (out_sop),
   .out_eop   (out_eop),
   .out_data  (out_data),
   .hold_full (hold_full)
);

// File: tb/test_pkt_rr_mux.sv
`timescale 1ns/1ps
module test_pkt_rr_mux;

   localparam int NS = 4;
   localparam int DW = 512;
   localparam int W  = DW / 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [NS-1:0]    src_valid = '0, src_sop = '0, src_eop = '0;
   logic [NS-1:0]    src_ready;
   logic [NS*DW-1:0] src_data = '0;
   logic             out_valid, out_sop, out_eop;
   logic             out_ready = 1'b1;
   logic [DW-1:0]    out_data;

   pkt_rr_mux #(.NUM_SRC(NS), .DATA_W(DW)) i_pkt_rr_mux (
      .clk(clk), .rst_n(rst_n),
      .src_valid(src_valid), .src_ready(src_ready),
      .src_sop(src_sop), .src_eop(src_eop), .src_data(src_data),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
   );

   // entry: {sop, eop, tag}; tag = {src[3:0], pkt[11:0], beat[15:0]}
   logic [33:0] srcq  [NS][$];
   logic [33:0] sentq [NS][$];
   logic [33:0] outq  [$];

   int checks = 0, errors = 0;
   int pktcnt [NS];
   int rdy_mode = 0;
   bit gap_mode = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   int cyc = 0;
   int v_onehot = 0, v_stable = 0, v_stallacc = 0, v_data = 0, run_acc = 0;
   logic p_ov = 1'b0, p_or = 1'b0, p_sop = 1'b0, p_eop = 1'b0;
   logic [DW-1:0] p_data = '0;

   // stimulus and monitor: drive at the falling edge, observe 1 ns later
   always @(negedge clk) begin
      int acc_n;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc++;
      for (int s = 0; s < NS; s++) begin
         if (rst_n && srcq[s].size() > 0 && !(gap_mode && lfsr[s+4])) begin
            src_valid[s] = 1'b1;
            src_sop[s]   = srcq[s][0][33];
            src_eop[s]   = srcq[s][0][32];
            src_data[s*DW +: DW] = {W{srcq[s][0][31:0]}};
         end else begin
            src_valid[s] = 1'b0;
            src_sop[s]   = 1'b0;
            src_eop[s]   = 1'b0;
            src_data[s*DW +: DW] = '0;
         end
      end
      case (rdy_mode)
         1:       out_ready = lfsr[0] | lfsr[7];
         2:       out_ready = (cyc % 10) >= 7;
         default: out_ready = 1'b1;
      endcase
      #1;
      if (rst_n) begin
         acc_n = 0;
         for (int s = 0; s < NS; s++) begin
            if (src_valid[s] && src_ready[s]) begin
               acc_n++;
               void'(srcq[s].pop_front());
            end
         end
         if (!$onehot0(src_ready)) v_onehot++;
         if (p_ov && !p_or) begin
            if (!out_valid || out_sop != p_sop || out_eop != p_eop || out_data != p_data)
               v_stable++;
         end
         if (out_valid && !out_ready) begin
            run_acc += acc_n;
            if (run_acc > 1) v_stallacc++;
         end else begin
            run_acc = 0;
         end
         if (out_valid && out_ready) begin
            outq.push_back({out_sop, out_eop, out_data[31:0]});
            if (out_data != {W{out_data[31:0]}}) v_data++;
         end
         p_ov = out_valid; p_or = out_ready; p_sop = out_sop;
         p_eop = out_eop;  p_data = out_data;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input string act, input string exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %s expected %s", req, what, act, exp);
      end
   endtask

   task automatic push_pkt(input int s, input int len);
      for (int b = 0; b < len; b++) begin
         logic [31:0] tag;
         logic [33:0] e;
         tag = {4'(s), 12'(pktcnt[s]), 16'(b)};
         e = {(b == 0), (b == len - 1), tag};
         srcq[s].push_back(e);
         sentq[s].push_back(e);
      end
      pktcnt[s]++;
   endtask

   task automatic settle_and_check(input string name, input string exp_order);
      int guard = 0, idle = 0, total = 0, mism = 0, atom = 0;
      bit in_pkt = 1'b0;
      logic [3:0] cur = '0;
      string act = "";
      while (idle < 4 && guard < 3000) begin
         bit busy;
         @(negedge clk); #2;
         guard++;
         busy = out_valid;
         for (int s = 0; s < NS; s++) if (srcq[s].size() > 0) busy = 1'b1;
         idle = busy ? 0 : idle + 1;
      end
      for (int s = 0; s < NS; s++) total += sentq[s].size();
      check(outq.size() == total, "R7", {name, " beat count"},
            $sformatf("%0d", outq.size()), $sformatf("%0d", total));
      for (int s = 0; s < NS; s++) begin
         int k = 0;
         foreach (outq[i]) begin
            if (outq[i][31:28] == 4'(s)) begin
               if (k >= sentq[s].size() || outq[i] != sentq[s][k]) mism++;
               k++;
            end
         end
         if (k != sentq[s].size()) mism++;
      end
      check(mism == 0, "R7", {name, " per-source stream"},
            $sformatf("%0d mismatches", mism), "0 mismatches");
      foreach (outq[i]) begin
         if (outq[i][33]) begin
            if (in_pkt) atom++;
            cur = outq[i][31:28];
            in_pkt = !outq[i][32];
            act = {act, $sformatf("%0d", outq[i][31:28])};
         end else begin
            if (!in_pkt || outq[i][31:28] != cur) atom++;
            if (outq[i][32]) in_pkt = 1'b0;
         end
      end
      check(atom == 0, "R3", {name, " packet atomicity"},
            $sformatf("%0d breaks", atom), "0 breaks");
      if (exp_order != "")
         check(act == exp_order, "R4", {name, " service order"}, act, exp_order);
      check(v_onehot == 0, "R2", {name, " ready one-hot"},
            $sformatf("%0d", v_onehot), "0");
      check(v_stable == 0, "R5", {name, " outputs held in stall"},
            $sformatf("%0d", v_stable), "0");
      check(v_stallacc == 0, "R6", {name, " one beat per stall"},
            $sformatf("%0d", v_stallacc), "0");
      check(v_data == 0, "R7", {name, " data unchanged"},
            $sformatf("%0d", v_data), "0");
      check(!out_valid && src_ready == '0, "R8", {name, " idle after drain"},
            $sformatf("valid=%0b ready=%b", out_valid, src_ready), "valid=0 ready=0000");
      for (int s = 0; s < NS; s++) sentq[s].delete();
      outq.delete();
      v_onehot = 0; v_stable = 0; v_stallacc = 0; v_data = 0;
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); #2;
      check(!out_valid && src_ready == '0, "R1", "reset state",
            $sformatf("valid=%0b ready=%b", out_valid, src_ready), "valid=0 ready=0000");
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk); #2;
      check(!out_valid && src_ready == '0, "R1", "state after reset release",
            $sformatf("valid=%0b ready=%b", out_valid, src_ready), "valid=0 ready=0000");
   endtask

   task automatic t_first_priority();
      rdy_mode = 0; gap_mode = 1'b0;
      @(posedge clk);
      for (int s = 0; s < NS; s++) push_pkt(s, 1);
      settle_and_check("R1 first priority", "0123");
   endtask

   task automatic t_rotate();
      rdy_mode = 0; gap_mode = 1'b0;
      @(posedge clk); push_pkt(2, 2);
      settle_and_check("R4 single", "2");
      @(posedge clk); push_pkt(1, 3); push_pkt(3, 1);
      settle_and_check("R4 after 2", "31");
      @(posedge clk); push_pkt(0, 2); push_pkt(1, 2);
      settle_and_check("R4 after 1", "01");
      @(posedge clk); push_pkt(1, 1); push_pkt(1, 2);
      settle_and_check("R4 repeat alone", "11");
   endtask

   task automatic t_full_load();
      rdy_mode = 0; gap_mode = 1'b0;
      @(posedge clk);
      for (int p = 0; p < 3; p++)
         for (int s = 0; s < NS; s++) push_pkt(s, 1 + (s + p) % 3);
      settle_and_check("R4 full load", "230123012301");
   endtask

   task automatic t_random_stall();
      rdy_mode = 1; gap_mode = 1'b1;
      @(posedge clk);
      for (int p = 0; p < 5; p++)
         for (int s = 0; s < NS; s++) push_pkt(s, 1 + (s * 3 + p) % 5);
      settle_and_check("R6 random stall", "");
   endtask

   task automatic t_long_stall();
      rdy_mode = 2; gap_mode = 1'b0;
      @(posedge clk);
      for (int p = 0; p < 4; p++)
         for (int s = 0; s < NS; s++) push_pkt(s, 1 + (s + 2 * p) % 4);
      settle_and_check("R5 long stall", "");
      rdy_mode = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int s = 0; s < NS; s++) pktcnt[s] = 0;
      t_reset();
      t_first_priority();
      t_rotate();
      t_full_load();
      t_random_stall();
      t_long_stall();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule